// File: doc/BRIEF.md
# Endpoint Packet-Buffer Segment Allocator

This block hands out contiguous regions of a shared endpoint packet-buffer RAM. The RAM is divided into 512-byte units, and a 128-bit occupancy map records which units are taken. A chip places one instance in front of the transmit pool and another in front of the receive pool. The packet RAM itself sits outside the block.

An allocate request carries a max packet size and a slot count. The block rounds the packet size up to a power-of-two segment and multiplies the segment by slots+1 to get the region size. It then searches the map, lowest index first, for enough free units in a row. It returns the byte address of the region and its size, or it raises a fail flag. A free request carries a byte address and a size, and the block clears the units those cover. A unit limit input narrows the part of the map that may be granted. The `units_used` output reports the number of occupied units.

The controller is a state machine with six states:
- `S_IDLE` waits for a request.
- `S_SIZE` latches the computed unit count.
- `S_SCAN` walks the map one unit per cycle.
- `S_GRANT` marks the units taken and pulses done.
- `S_DENY` pulses done with fail.
- `S_RELEASE` clears units and pulses done.

The transitions are:
- IDLE→SIZE on an allocate request.
- IDLE→RELEASE on a free request.
- SIZE→DENY when the request is larger than the limit.
- SIZE→SCAN otherwise.
- SCAN→GRANT when a run of free units is found.
- SCAN→DENY when the scan reaches the limit.
- GRANT, DENY and RELEASE each return to IDLE.

Top module: `seg_pool_alloc`

## Requirements
- R1: After reset the map is empty: `units_used` is 0, and `done` and `busy` are 0.
- R2: The segment size is the max packet size rounded up to a power of two, with a packet size of 0 taken as 1. `grant_size` is (slots+1) times the segment size, in bytes.
- R3: A grant reserves ceil(`grant_size`/512) units, and `units_used` grows by exactly that count.
- R4: A grant uses the lowest unit index at which enough consecutive free units exist. `grant_addr` = `pool_base` + index×512, and the granted units never overlap units already taken.
- R5: No unit at or above the effective limit is granted. The effective limit is `unit_limit`, capped at 128.
- R6: When no run of free units is long enough, `done` and `fail` pulse together and the map is left unchanged.
- R7: A free clears exactly ceil(`free_size`/512) units, starting at unit (`free_addr`−`pool_base`)/512. All other units keep their state.
- R8: Each accepted request gives exactly one `done` pulse, one cycle long. For a free, the pulse comes in the cycle right after the request is accepted.
- R9: Requests are accepted only while `busy` is 0, and requests made while busy are ignored. When both request inputs are high at once, the allocate is taken and the free is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pool_base | input | ADDR_W | Byte address of unit 0 of the pool |
| unit_limit | input | LIM_W | Number of units that may be granted (capped at MAP_BITS) |
| req_alloc | input | 1 | Allocate request, sampled while idle |
| maxp | input | MAXP_W | Max packet size in bytes |
| slots | input | SLOT_W | Slot count; the region holds slots+1 segments |
| req_free | input | 1 | Free request, sampled while idle |
| free_addr | input | ADDR_W | Byte address of the region to release |
| free_size | input | TOT_W | Byte size of the region to release |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Allocation failed; valid with done |
| grant_addr | output | ADDR_W | Granted byte address; valid with done and not fail |
| grant_size | output | TOT_W | Granted region size in bytes |
| units_used | output | LIM_W | Number of occupied units |

## Verification
The bench frees a region in the middle of the map and then issues requests that fit the hole, and others one unit too large for it. A first-fit error would place those grants at the wrong index, and a free that cleared too much or too little would show up in `units_used`. It drives packet sizes of 0, just over a power of two, and the largest value, to catch wrong rounding. It sets limits just past a region, and a limit above the map width, to catch grants past the limit or a missing cap. It also raises request inputs while the block is busy, and both inputs at once. A design that accepted those requests would change `units_used` by the wrong amount.

// File: rtl/seg_alloc_pkg.sv
package seg_alloc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SIZE,
        S_SCAN,
        S_GRANT,
        S_DENY,
        S_RELEASE
    } alloc_state_e;

endpackage

// File: rtl/seg_size_calc.sv
module seg_size_calc #(
    parameter int MAXP_W  = 11,
    parameter int SLOT_W  = 3,
    parameter int UNIT_LG = 9,
    localparam int SEG_W  = MAXP_W + 1,
    localparam int TOT_W  = SEG_W + SLOT_W + 1,
    localparam int CNT_W  = TOT_W + 1
) (
    input  logic [MAXP_W-1:0] maxp,
    input  logic [SLOT_W-1:0] slots,
    output logic [SEG_W-1:0]  seg_bytes,
    output logic [TOT_W-1:0]  region_bytes,
    output logic [CNT_W-1:0]  unit_cnt
);
    logic [SLOT_W:0] mult;
    logic [CNT_W-1:0] rounded;

    always_comb begin
        seg_bytes = SEG_W'(1);
        for (int i = 0; i < MAXP_W; i++) begin
            if ((SEG_W'(1) << i) < {1'b0, maxp})
                seg_bytes = SEG_W'(1) << (i + 1);
        end
    end

    assign mult         = {1'b0, slots} + (SLOT_W+1)'(1);
    assign region_bytes = TOT_W'(seg_bytes) * TOT_W'(mult);
    assign rounded      = {1'b0, region_bytes} + CNT_W'((1 << UNIT_LG) - 1);
    assign unit_cnt     = rounded >> UNIT_LG;

endmodule

// File: rtl/seg_range_mask.sv
module seg_range_mask #(
    parameter int MAP_BITS = 128,
    parameter int POS_W    = 32,
    parameter int CNT_W    = 17
) (
    input  logic [POS_W-1:0]    start,
    input  logic [CNT_W-1:0]    count,
    output logic [MAP_BITS-1:0] mask
);
    logic [POS_W:0] end_pos;

    assign end_pos = {1'b0, start} + (POS_W+1)'(count);

    always_comb begin
        for (int i = 0; i < MAP_BITS; i++)
            mask[i] = (POS_W'(i) >= start) && ((POS_W+1)'(i) < end_pos);
    end

endmodule

// File: rtl/seg_popcount.sv
module seg_popcount #(
    parameter int MAP_BITS = 128,
    parameter int OUT_W    = 8
) (
    input  logic [MAP_BITS-1:0] bits,
    output logic [OUT_W-1:0]    total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < MAP_BITS; i++)
            total = total + OUT_W'(bits[i]);
    end

endmodule

// File: rtl/seg_pool_alloc.sv
module seg_pool_alloc
    import seg_alloc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAP_BITS   = 128,
    parameter int UNIT_BYTES = 512,
    parameter int MAXP_W     = 11,
    parameter int SLOT_W     = 3,
    localparam int UNIT_LG   = $clog2(UNIT_BYTES),
    localparam int IDX_W     = $clog2(MAP_BITS),
    localparam int LIM_W     = IDX_W + 1,
    localparam int SEG_W     = MAXP_W + 1,
    localparam int TOT_W     = SEG_W + SLOT_W + 1,
    localparam int CNT_W     = TOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pool_base,
    input  logic [LIM_W-1:0]  unit_limit,
    input  logic              req_alloc,
    input  logic [MAXP_W-1:0] maxp,
    input  logic [SLOT_W-1:0] slots,
    input  logic              req_free,
    input  logic [ADDR_W-1:0] free_addr,
    input  logic [TOT_W-1:0]  free_size,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] grant_addr,
    output logic [TOT_W-1:0]  grant_size,
    output logic [LIM_W-1:0]  units_used
);
    alloc_state_e state_q, state_n;

    logic [MAP_BITS-1:0] map_q;
    logic [MAP_BITS-1:0] range_mask;
    logic [ADDR_W-1:0]   start_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [LIM_W-1:0]    scan_idx;
    logic [CNT_W-1:0]    run_q;
    logic [MAXP_W-1:0]   maxp_q;
    logic [SLOT_W-1:0]   slots_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [TOT_W-1:0]    size_q;

    logic [SEG_W-1:0]    seg_bytes;
    logic [TOT_W-1:0]    region_bytes;
    logic [CNT_W-1:0]    unit_cnt;
    logic [LIM_W-1:0]    eff_limit;
    logic [ADDR_W-1:0]   free_off;
    logic [ADDR_W-1:0]   free_idx;
    logic [CNT_W-1:0]    free_units;
    logic [CNT_W-1:0]    free_round;
    logic                scan_end;
    logic                cell_free;
    logic [CNT_W-1:0]    run_n;
    logic                hit;
    logic [ADDR_W-1:0]   start_hit;

    seg_size_calc #(.MAXP_W(MAXP_W), .SLOT_W(SLOT_W), .UNIT_LG(UNIT_LG)) i_size (
        .maxp         (maxp_q),
        .slots        (slots_q),
        .seg_bytes    (seg_bytes),
        .region_bytes (region_bytes),
        .unit_cnt     (unit_cnt)
    );

    seg_range_mask #(.MAP_BITS(MAP_BITS), .POS_W(ADDR_W), .CNT_W(CNT_W)) i_mask (
        .start (start_q),
        .count (cnt_q),
        .mask  (range_mask)
    );

    seg_popcount #(.MAP_BITS(MAP_BITS), .OUT_W(LIM_W)) i_count (
        .bits  (map_q),
        .total (units_used)
    );

    assign eff_limit  = (unit_limit > LIM_W'(MAP_BITS)) ? LIM_W'(MAP_BITS) : unit_limit;
    assign free_off   = free_addr - pool_base;
    assign free_idx   = free_off >> UNIT_LG;
    assign free_round = {1'b0, free_size} + CNT_W'(UNIT_BYTES - 1);
    assign free_units = free_round >> UNIT_LG;

    assign scan_end  = scan_idx >= eff_limit;
    assign cell_free = !map_q[scan_idx[IDX_W-1:0]];
    assign run_n     = cell_free ? run_q + CNT_W'(1) : '0;
    assign hit       = !scan_end && cell_free && (run_n == cnt_q);
    assign start_hit = ADDR_W'(scan_idx) + ADDR_W'(1) - ADDR_W'(cnt_q);

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_alloc)     state_n = S_SIZE;
                else if (req_free) state_n = S_RELEASE;
            end
            S_SIZE: begin
                if (unit_cnt > CNT_W'(eff_limit)) state_n = S_DENY;
                else                              state_n = S_SCAN;
            end
            S_SCAN: begin
                if (scan_end) state_n = S_DENY;
                else if (hit) state_n = S_GRANT;
            end
            S_GRANT:   state_n = S_IDLE;
            S_DENY:    state_n = S_IDLE;
            S_RELEASE: state_n = S_IDLE;
            default:   state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q    <= '0;
            start_q  <= '0;
            cnt_q    <= '0;
            scan_idx <= '0;
            run_q    <= '0;
            maxp_q   <= '0;
            slots_q  <= '0;
            addr_q   <= '0;
            size_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_alloc) begin
                        maxp_q  <= maxp;
                        slots_q <= slots;
                    end else if (req_free) begin
                        start_q <= free_idx;
                        cnt_q   <= free_units;
                    end
                end
                S_SIZE: begin
                    cnt_q    <= unit_cnt;
                    size_q   <= region_bytes;
                    scan_idx <= '0;
                    run_q    <= '0;
                end
                S_SCAN: begin
                    scan_idx <= scan_idx + LIM_W'(1);
                    run_q    <= run_n;
                    if (hit) begin
                        start_q <= start_hit;
                        addr_q  <= pool_base + (start_hit << UNIT_LG);
                    end
                end
                S_GRANT:   map_q <= map_q | range_mask;
                S_RELEASE: map_q <= map_q & ~range_mask;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        done       = (state_q == S_GRANT) || (state_q == S_DENY) || (state_q == S_RELEASE);
        fail       = (state_q == S_DENY);
        grant_addr = addr_q;
        grant_size = size_q;
    end

    // R3: a grant adds exactly its unit count to the occupancy
    p_used_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GRANT) |=> (units_used == $past(units_used) + LIM_W'($past(cnt_q))));

    // R4: granted units were all free
    p_grant_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GRANT) |-> ((map_q & range_mask) == '0));

    // R5: the granted range ends at or below the effective limit
    p_grant_in_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GRANT) |-> (({1'b0, start_q} + (ADDR_W+1)'(cnt_q)) <= (ADDR_W+1)'(eff_limit)));

    // R6: a refusal leaves the map unchanged
    p_deny_keeps_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DENY) |=> (map_q == $past(map_q)));

    // R7: a release never sets a unit
    p_release_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RELEASE) |=> ((map_q & ~$past(map_q)) == '0));

    // R8: done lasts one cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: an idle block leaves idle only on a request
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_alloc && !req_free) |=> !busy);

endmodule

// File: tb/test_seg_pool_alloc.sv
module test_seg_pool_alloc;
    localparam logic [31:0] BASE = 32'h0004_0000;
    localparam int NV = 9;
    // {op, a, b, fail, idx, size, used}: op 0 alloc (a=maxp, b=slots), op 1 free (a=unit idx, b=bytes)
    localparam logic [66:0] VEC [NV] = '{
        {1'b0, 16'd512,  16'd2,    1'b0, 8'd0,  17'd1536,  8'd3},
        {1'b0, 16'd1024, 16'd1,    1'b0, 8'd3,  17'd2048,  8'd7},
        {1'b0, 16'd100,  16'd0,    1'b0, 8'd7,  17'd128,   8'd8},
        {1'b0, 16'd0,    16'd0,    1'b0, 8'd8,  17'd1,     8'd9},
        {1'b0, 16'd513,  16'd3,    1'b0, 8'd9,  17'd4096,  8'd17},
        {1'b1, 16'd3,    16'd2048, 1'b0, 8'd0,  17'd0,     8'd13},
        {1'b0, 16'd64,   16'd7,    1'b0, 8'd3,  17'd512,   8'd14},
        {1'b0, 16'd1024, 16'd1,    1'b0, 8'd17, 17'd2048,  8'd18},
        {1'b0, 16'd2047, 16'd7,    1'b0, 8'd21, 17'd16384, 8'd50}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pool_base = BASE;
    logic [7:0]  unit_limit = 8'd128;
    logic        req_alloc = 1'b0;
    logic [10:0] maxp = '0;
    logic [2:0]  slots = '0;
    logic        req_free = 1'b0;
    logic [31:0] free_addr = '0;
    logic [15:0] free_size = '0;
    logic        busy, done, fail;
    logic [31:0] grant_addr;
    logic [15:0] grant_size;
    logic [7:0]  units_used;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic        r_fail;
    logic [31:0] r_addr;
    logic [15:0] r_size;

    always #5 clk = ~clk;

    seg_pool_alloc i_seg_pool_alloc (
        .clk(clk), .rst_n(rst_n), .pool_base(pool_base), .unit_limit(unit_limit),
        .req_alloc(req_alloc), .maxp(maxp), .slots(slots), .req_free(req_free),
        .free_addr(free_addr), .free_size(free_size), .busy(busy), .done(done),
        .fail(fail), .grant_addr(grant_addr), .grant_size(grant_size),
        .units_used(units_used)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        int pulses = 0;
        for (int c = 0; c < 400; c++) begin
            if (done) begin
                r_fail = fail; r_addr = grant_addr; r_size = grant_size;
                pulses++;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        if (done) pulses++;
        chk("R8 done pulse count", pulses, 1);
    endtask

    task automatic do_alloc(input logic [10:0] mp, input logic [2:0] sl);
        @(negedge clk);
        maxp = mp; slots = sl; req_alloc = 1'b1;
        @(negedge clk);
        req_alloc = 1'b0;
        wait_done();
    endtask

    task automatic do_free(input int idx, input logic [15:0] sz);
        @(negedge clk);
        free_addr = BASE + 32'(idx) * 512; free_size = sz; req_free = 1'b1;
        @(negedge clk);
        req_free = 1'b0;
        chk("R8 free done next cycle", {31'd0, done}, 1);
        @(negedge clk);
        chk("R8 free done single", {31'd0, done}, 0);
    endtask

    task automatic expect_grant(input string tag, input int idx, input int used);
        chk({tag, " R6 fail flag"}, {31'd0, r_fail}, 0);
        chk({tag, " R4 address"}, r_addr, BASE + 32'(idx) * 512);
        chk({tag, " R3 units used"}, {24'd0, units_used}, used);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset used", {24'd0, units_used}, 0);
        chk("R1 reset done", {31'd0, done}, 0);
        chk("R1 reset busy", {31'd0, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 sizes, R4 first fit, R7 free of a middle region
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][66]) begin
                do_free(int'(VEC[v][65:50]), VEC[v][49:34]);
                chk("R7 units after free", {24'd0, units_used}, {24'd0, VEC[v][7:0]});
            end else begin
                do_alloc(VEC[v][60:50], VEC[v][36:34]);
                chk("R2 grant size", {16'd0, r_size}, {15'd0, VEC[v][24:8]});
                expect_grant("table", int'(VEC[v][32:25]), int'(VEC[v][7:0]));
            end
        end

        // R5 limit of 60 units
        unit_limit = 8'd60;
        do_alloc(11'd1024, 3'd1);
        expect_grant("R5 near limit", 53, 54);
        do_alloc(11'd1024, 3'd1);
        chk("R6 no run fail", {31'd0, r_fail}, 1);
        chk("R6 map unchanged", {24'd0, units_used}, 54);
        do_alloc(11'd512, 3'd2);
        expect_grant("R4 hole reuse", 4, 57);

        // R7 partial size rounds to one unit
        do_free(7, 16'd100);
        chk("R7 one unit cleared", {24'd0, units_used}, 56);
        do_alloc(11'd1, 3'd0);
        expect_grant("R7 refill", 7, 57);

        // R9 free raised while busy is ignored
        @(negedge clk);
        maxp = 11'd64; slots = 3'd0; req_alloc = 1'b1;
        @(negedge clk);
        req_alloc = 1'b0; free_addr = BASE; free_size = 16'd512; req_free = 1'b1;
        @(negedge clk);
        req_free = 1'b0;
        wait_done();
        expect_grant("R9 busy ignore", 57, 58);

        // R9 both requests at once: allocate wins
        @(negedge clk);
        maxp = 11'd64; slots = 3'd0; req_alloc = 1'b1;
        free_addr = BASE; free_size = 16'd512; req_free = 1'b1;
        @(negedge clk);
        req_alloc = 1'b0; req_free = 1'b0;
        wait_done();
        expect_grant("R9 alloc priority", 58, 59);

        // R5 last unit below the limit, then refusal
        do_alloc(11'd64, 3'd0);
        expect_grant("R5 last unit", 59, 60);
        do_alloc(11'd64, 3'd0);
        chk("R5 at limit fail", {31'd0, r_fail}, 1);
        chk("R5 at limit used", {24'd0, units_used}, 60);

        // R5 limit above map width is capped
        unit_limit = 8'd200;
        do_alloc(11'd2047, 3'd7);
        expect_grant("R5 cap a", 60, 92);
        do_alloc(11'd2047, 3'd7);
        expect_grant("R5 cap b", 92, 124);
        do_alloc(11'd2047, 3'd7);
        chk("R5 cap fail", {31'd0, r_fail}, 1);
        do_alloc(11'd1024, 3'd1);
        expect_grant("R5 map end", 124, 128);

        // R1 reset clears the map
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears used", {24'd0, units_used}, 0);
        rst_n = 1'b1;
        do_alloc(11'd512, 3'd0);
        expect_grant("R1 after reset", 0, 1);

        summary();
    end
endmodule